// File: doc/BRIEF.md
# Dependency-Distance Write-Skip Tracker

This block sits beside an out-of-order scheduler. It decides, for each instruction that issues, whether the result may bypass the write into the reorder buffer and the architectural register file. Each instruction carries a 2-bit hint from the compiler. The hint bounds how far ahead, in program order, the last reader of its result can sit. A result is safe to drop only if every reader that could exist has already been dispatched, because those readers will then pick the value up from the bypass network.

To track this, the block keeps an occupancy vector with one bit per reorder-buffer slot. Dispatch fills slots in order at the tail and retirement frees them in order at the head. An issuing instruction names its own slot and hint. The block turns the hint into the furthest possible reader distance. It then checks that the slot at that distance is occupied and lies no further than the newest dispatched instruction. One cycle after the issue strobe, the answer appears on the skip output together with a valid flag.

Top module: `depdist_skip_tracker`

## Requirements
- R1: After reset, or while reset is held, the tracker is empty, `disp_slot_o` is 0, and `skip_vld_o` and `skip_o` are 0.
- R2: Each accepted dispatch takes the slot shown on `disp_slot_o`, and `disp_slot_o` then moves to the next slot. After slot DEPTH-1 it wraps to slot 0.
- R3: Each accepted retire frees the oldest occupied slot. After that, the slot no longer counts as occupied for issue checks.
- R4: A dispatch while all DEPTH slots are occupied is dropped, and `disp_slot_o` does not move.
- R5: A retire while no slot is occupied is dropped, and later occupancy is unaffected.
- R6: A dispatch and a retire in the same cycle both take effect when each is allowed on its own. On a full tracker the retire alone takes effect, and on an empty tracker the dispatch alone takes effect.
- R7: Hint code 2'b00 means the reader distance is unbounded, and the result is always written (`skip_o` = 0).
- R8: Hint codes 2'b01, 2'b10 and 2'b11 cover reader distances 1, 2..3 and 4..7. The tracker tests the slot at the upper bound (issuing slot + 1, + 3 or + 7, modulo DEPTH). `skip_o` is 1 when that slot holds a dispatched, unretired instruction.
- R9: If the tested slot lies beyond the newest dispatched instruction, the write is forced (`skip_o` = 0). This holds even when the position wraps around onto an occupied older slot.
- R10: `skip_vld_o` and `skip_o` are registered. They reflect an issue in the cycle after `iss_vld_i`, and they are judged against the occupancy before that cycle's dispatch and retire take effect. Without an issue, both are 0.
- R11: An issue that names a slot not currently occupied is never skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disp_i | input | 1 | Dispatch strobe: allocate the next slot |
| ret_i | input | 1 | Retire strobe: free the oldest slot |
| iss_vld_i | input | 1 | Issue strobe |
| iss_slot_i | input | $clog2(DEPTH) | Slot of the issuing instruction |
| iss_hint_i | input | 2 | Distance hint of the issuing instruction |
| disp_slot_o | output | $clog2(DEPTH) | Slot the next dispatch will take |
| skip_vld_o | output | 1 | Issue decision valid (one cycle after issue) |
| skip_o | output | 1 | 1: write to ROB and ARF may be skipped |

## Verification
The bench targets several corner cases:
- **Window edges.** An issue that tests exactly the newest slot is skipped, and one that tests one slot past it is not. A design comparing against the wrong bound would drop a live value.
- **Full wrap-around.** A test position that wraps onto an occupied older slot must still force the write. A design that only reads the vector bit would skip here.
- **Strobes at the limits.** A dispatch on a full tracker must not move the tail, and a retire on an empty tracker must not underflow. Either fault corrupts every later decision.
- **Decision timing.** A same-cycle dispatch must not influence the decision. Testing it exposes a design that looks at next-state occupancy.
- **Stale slots.** An issue on an already-retired slot must never be skipped.

// File: rtl/wsk_pkg.sv
package wsk_pkg;

  typedef enum logic [1:0] {
    HINT_INF   = 2'b00,
    HINT_ONE   = 2'b01,
    HINT_UPTO3 = 2'b10,
    HINT_UPTO7 = 2'b11
  } hint_e;

  localparam int REACH_W = 3;

  // Upper bound of the reader distance covered by a hint code.
  function automatic logic [REACH_W-1:0] hint_reach(input hint_e h);
    logic [REACH_W-1:0] r;
    case (h)
      HINT_ONE:   r = 3'd1;
      HINT_UPTO3: r = 3'd3;
      HINT_UPTO7: r = 3'd7;
      default:    r = 3'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wsk_presence_vec.sv
module wsk_presence_vec #(
  parameter int DEPTH  = 128,
  parameter int SLOT_W = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_i,
  input  logic              ret_i,
  output logic [DEPTH-1:0]  pv_o,
  output logic [SLOT_W-1:0] head_o,
  output logic [SLOT_W-1:0] tail_o,
  output logic [CNT_W-1:0]  count_o
);

  logic [DEPTH-1:0]  pv_q, pv_d;
  logic [SLOT_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              full, empty, do_disp, do_ret, upd_en;

  function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(DEPTH - 1)) ? '0 : p + SLOT_W'(1);
  endfunction

  always_comb begin
    full    = (count_q == CNT_W'(DEPTH));
    empty   = (count_q == '0);
    do_disp = disp_i && !full;
    do_ret  = ret_i && !empty;
    upd_en  = do_disp || do_ret;

    tail_d  = do_disp ? bump(tail_q) : tail_q;
    head_d  = do_ret  ? bump(head_q) : head_q;

    case ({do_disp, do_ret})
      2'b10:   count_d = count_q + CNT_W'(1);
      2'b01:   count_d = count_q - CNT_W'(1);
      default: count_d = count_q;
    endcase

    pv_d = pv_q;
    if (do_disp) pv_d[tail_q] = 1'b1;
    if (do_ret)  pv_d[head_q] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q    <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (upd_en) begin
      pv_q    <= pv_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign pv_o    = pv_q;
  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));

  assert_full_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_W'(DEPTH) && disp_i && !ret_i) |=> $stable(tail_q));

  assert_empty_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && ret_i && !disp_i) |=> $stable(head_q));

  assert_pop_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pv_q) == 32'(count_q));

  assert_head_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q != '0) |-> pv_q[head_q]);

endmodule

// File: rtl/wsk_issue_check.sv
module wsk_issue_check
  import wsk_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int SLOT_W = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEPTH-1:0]  pv_i,
  input  logic [SLOT_W-1:0] head_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              iss_vld_i,
  input  logic [SLOT_W-1:0] iss_slot_i,
  input  logic [1:0]        iss_hint_i,
  output logic              skip_vld_o,
  output logic              skip_o
);

  localparam int OFF_W = CNT_W + 1;

  hint_e             hint;
  logic [OFF_W-1:0]  slot_ext, head_ext, reach_ext, own_off, far_off, pos_raw, pos_fold;
  logic [SLOT_W-1:0] test_pos;
  logic              in_window, hit;
  logic              skip_vld_q, skip_vld_d, skip_q, skip_d;

  // Distance of the tested slot from the oldest entry, and its wrapped index.
  always_comb begin
    hint      = hint_e'(iss_hint_i);
    slot_ext  = OFF_W'(iss_slot_i);
    head_ext  = OFF_W'(head_i);
    reach_ext = OFF_W'(hint_reach(hint));
    own_off   = (slot_ext >= head_ext) ? (slot_ext - head_ext)
                                       : (slot_ext + OFF_W'(DEPTH) - head_ext);
    far_off   = own_off + reach_ext;
    pos_raw   = slot_ext + reach_ext;
    pos_fold  = (pos_raw >= OFF_W'(DEPTH)) ? (pos_raw - OFF_W'(DEPTH)) : pos_raw;
    test_pos  = SLOT_W'(pos_fold);
    in_window = (far_off < OFF_W'(count_i));
    hit       = (hint != HINT_INF) && in_window && pv_i[test_pos];
    skip_vld_d = iss_vld_i;
    skip_d     = iss_vld_i && hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_vld_q <= 1'b0;
      skip_q     <= 1'b0;
    end else begin
      skip_vld_q <= skip_vld_d;
      skip_q     <= skip_d;
    end
  end

  assign skip_vld_o = skip_vld_q;
  assign skip_o     = skip_q;

  assert_inf_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_vld_i && iss_hint_i == 2'b00) |=> (skip_vld_o && !skip_o));

  assert_valid_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_vld_i |=> skip_vld_o);

  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iss_vld_i |=> (!skip_vld_o && !skip_o));

  assert_empty_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_vld_i && count_i == '0) |=> !skip_o);

endmodule

// File: rtl/depdist_skip_tracker.sv
module depdist_skip_tracker #(
  parameter int DEPTH = 128,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_i,
  input  logic              ret_i,
  input  logic              iss_vld_i,
  input  logic [SLOT_W-1:0] iss_slot_i,
  input  logic [1:0]        iss_hint_i,
  output logic [SLOT_W-1:0] disp_slot_o,
  output logic              skip_vld_o,
  output logic              skip_o
);

  logic [DEPTH-1:0]  pv;
  logic [SLOT_W-1:0] head, tail;
  logic [CNT_W-1:0]  count;

  wsk_presence_vec #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_pvec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .disp_i  (disp_i),
    .ret_i   (ret_i),
    .pv_o    (pv),
    .head_o  (head),
    .tail_o  (tail),
    .count_o (count)
  );

  wsk_issue_check #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_check (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pv_i       (pv),
    .head_i     (head),
    .count_i    (count),
    .iss_vld_i  (iss_vld_i),
    .iss_slot_i (iss_slot_i),
    .iss_hint_i (iss_hint_i),
    .skip_vld_o (skip_vld_o),
    .skip_o     (skip_o)
  );

  assign disp_slot_o = tail;

endmodule

// File: tb/depdist_skip_tracker_tb.sv
`timescale 1ns/1ps
module depdist_skip_tracker_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       disp, ret, iss;
  logic [6:0] slot;
  logic [1:0] hint;
  logic [6:0] disp_slot;
  logic       skip_vld, skip;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  depdist_skip_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .disp_i(disp), .ret_i(ret),
    .iss_vld_i(iss), .iss_slot_i(slot), .iss_hint_i(hint),
    .disp_slot_o(disp_slot), .skip_vld_o(skip_vld), .skip_o(skip)
  );

  // Entry: {slot[6:0], hint[1:0], expected skip}. State: slots 0..9 occupied.
  localparam logic [9:0] TBL [12] = '{
    {7'd0,  2'b01, 1'b1},   // R8 distance 1
    {7'd0,  2'b10, 1'b1},   // R8 distance 3
    {7'd0,  2'b11, 1'b1},   // R8 distance 7
    {7'd2,  2'b11, 1'b1},   // R8 tests newest slot 9
    {7'd3,  2'b11, 1'b0},   // R9 one past newest
    {7'd8,  2'b01, 1'b1},   // R8
    {7'd9,  2'b01, 1'b0},   // R9
    {7'd5,  2'b00, 1'b0},   // R7 unbounded
    {7'd6,  2'b10, 1'b1},   // R8
    {7'd7,  2'b10, 1'b0},   // R9
    {7'd12, 2'b01, 1'b0},   // R11 unoccupied slot
    {7'd9,  2'b00, 1'b0}    // R7
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Inputs driven after a falling edge; outputs read at the next falling edge.
  task automatic step(input logic d, input logic r, input logic v, input int s, input int h);
    disp = d; ret = r; iss = v; slot = 7'(s); hint = 2'(h);
    @(negedge clk);
    disp = 1'b0; ret = 1'b0; iss = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; disp = 0; ret = 0; iss = 0; slot = '0; hint = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset disp_slot", int'(disp_slot), 0);
    chk("R1 reset skip_vld", int'(skip_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: fill slots 0..9
    for (int i = 0; i < 10; i++) begin
      step(1, 0, 0, 0, 0);
      chk("R2 dispatch order", int'(disp_slot), i + 1);
    end

    // R7 R8 R9 R11 table walk
    for (int i = 0; i < 12; i++) begin
      step(0, 0, 1, int'(TBL[i][9:3]), int'(TBL[i][2:1]));
      chk("R10 valid after issue", int'(skip_vld), 1);
      chk("R7 R8 R9 R11 table", int'(skip), int'(TBL[i][0]));
    end
    step(0, 0, 0, 0, 0);
    chk("R10 quiet without issue", int'(skip_vld), 0);

    // R3: retire 0..2
    repeat (3) step(0, 1, 0, 0, 0);
    step(0, 0, 1, 3, 1);
    chk("R3 oldest live slot", int'(skip), 1);
    step(0, 0, 1, 2, 1);
    chk("R3 retired slot no skip", int'(skip), 0);

    // R10: decision uses occupancy before the same-cycle dispatch
    step(1, 0, 1, 9, 1);
    chk("R10 pre-dispatch view", int'(skip), 0);
    step(0, 0, 1, 9, 1);
    chk("R10 after dispatch", int'(skip), 1);

    // R6: dispatch and retire together (head 3 -> 4, tail 11 -> 12)
    step(1, 1, 0, 0, 0);
    chk("R6 both act tail", int'(disp_slot), 12);
    step(0, 0, 1, 3, 1);
    chk("R6 both act head", int'(skip), 0);
    step(0, 0, 1, 10, 1);
    chk("R6 window kept", int'(skip), 1);

    // R5: drain, extra retire dropped
    repeat (8) step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 12, 1);
    chk("R5 empty retire dropped", int'(skip), 1);
    chk("R5 tail", int'(disp_slot), 14);

    // R2 wrap: fill to full (126 more)
    for (int i = 0; i < 126; i++) begin
      step(1, 0, 0, 0, 0);
      chk("R2 wrap order", int'(disp_slot), (15 + i) % 128);
    end
    step(1, 0, 0, 0, 0);
    chk("R4 full dispatch dropped", int'(disp_slot), 12);

    step(0, 0, 1, 11, 1);
    chk("R9 wrap onto oldest", int'(skip), 0);
    step(0, 0, 1, 120, 3);
    chk("R8 full high slot", int'(skip), 1);
    step(0, 0, 1, 126, 2);
    chk("R8 modulo wrap", int'(skip), 1);
    step(0, 0, 1, 6, 3);
    chk("R9 past newest full", int'(skip), 0);

    // R6 on full: only retire acts
    step(1, 1, 0, 0, 0);
    chk("R6 full retire only", int'(disp_slot), 12);
    step(1, 0, 0, 0, 0);
    chk("R6 slot reusable", int'(disp_slot), 13);

    // R1: reset mid-run
    step(0, 0, 1, 20, 1);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset slot", int'(disp_slot), 0);
    chk("R1 async reset valid", int'(skip_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule